// File: doc/BRIEF.md
# Virtual Address Segment Decoder

This block takes a 32-bit virtual address, the current privilege level and two status controls, and decides how the access proceeds. There are three outcomes. The block can form a physical address directly with no page lookup. It can tell the memory pipeline that the page tables must be consulted. It can flag an address error because the privilege level may not touch that region.

The address space splits into five regions by its top bits:

- a low half that every privilege level may use;
- two kernel-only windows that map straight onto the bottom 512 MiB of physical memory, one for cached use and one for uncached use;
- a page-mapped window open to supervisor and kernel;
- a page-mapped top window open to the kernel only.

An error-level control makes the low half an identity map. A fixed-map control removes page lookup entirely, using constant relocations instead.

The result is registered once by default (parameter `REG_OUT`), so outputs follow inputs by one clock. With `REG_OUT` = 0 the path is purely combinational.

Top module: `vseg_xlate`

## Requirements
- R1: For an address with bit 31 clear and `err_lvl` = 1, the result is direct with `paddr` equal to `vaddr`, in any privilege level and with `fixed_map` at either value.
- R2: For an address with bit 31 clear, `err_lvl` = 0 and `fixed_map` = 0, `need_tlb` is asserted in every privilege level.
- R3: `priv_mode` is encoded as 00 kernel, 01 supervisor, 10 user, and 11 is also treated as user. Any user access with bit 31 set raises `bad_addr`.
- R4: In kernel mode, with `fixed_map` = 0:
  - an address in 0x80000000–0x9FFFFFFF gives `paddr` = `vaddr` − 0x80000000;
  - an address in 0xA0000000–0xBFFFFFFF gives `paddr` = `vaddr` − 0xA0000000;
  - `err_lvl` has no effect on either range.
- R5: A supervisor access in 0x80000000–0xBFFFFFFF or at 0xE0000000 and above raises `bad_addr`.
- R6: With `fixed_map` = 0, `need_tlb` is asserted for a supervisor or kernel access in 0xC0000000–0xDFFFFFFF, and for a kernel access at 0xE0000000 and above.
- R7: With `fixed_map` = 1, and each case otherwise allowed by R3 and R5:
  - an address with bit 31 clear and `err_lvl` = 0 gives `paddr` = `vaddr` + 0x40000000;
  - an address in 0x80000000–0xBFFFFFFF gives `paddr` = `vaddr` AND 0x1FFFFFFF;
  - an address at 0xC0000000 and above gives `paddr` = `vaddr`;
  - none of these cases asserts `need_tlb`.
- R8: `rd_ok` and `wr_ok` are both 1 exactly when the result is direct, and both 0 when `bad_addr` or `need_tlb` is set.
- R9: `bad_addr` and `need_tlb` are never asserted together. While either is set, `paddr` carries no meaning.
- R10: With `REG_OUT` = 1, outputs reflect the inputs sampled at the previous rising clock edge, including on back-to-back changes. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| vaddr | input | 32 | Virtual address to classify |
| priv_mode | input | 2 | Privilege level: 00 kernel, 01 supervisor, 10/11 user |
| err_lvl | input | 1 | Error-level status; identity maps the low half |
| fixed_map | input | 1 | Fixed-mapping mode; replaces page lookup with constant relocation |
| paddr | output | 32 | Physical address, meaningful when the result is direct |
| need_tlb | output | 1 | Access must be translated through the page tables |
| bad_addr | output | 1 | Address error for this privilege level |
| rd_ok | output | 1 | Read permitted on a direct result |
| wr_ok | output | 1 | Write permitted on a direct result |

## Verification
The bench drives the region edges: 0x7FFFFFFF, 0x80000000, 0x9FFFFFFF, 0xA0000000, 0xBFFFFFFF, 0xC0000000, 0xDFFFFFFF, 0xE0000000 and 0xFFFFFFFF. A decoder that took its region boundaries from the wrong bits would translate one side of an edge wrongly, or let an access through that should fail.

Mode code 11 is driven to catch a decoder that treats it as kernel and leaks the kernel windows to user code. The error-level control is combined with high addresses and with fixed-map mode, to expose a design that lets it override privilege checks or the fixed relocation.

A full sweep over region, privilege, error level and map mode checks that an error and a lookup request never appear together. Each result is compared one clock after its inputs change.

// File: rtl/vseg_pkg.sv
package vseg_pkg;

    // Privilege level encoding on the priv_mode input.
    typedef enum logic [1:0] {
        PRIV_KERN    = 2'b00,
        PRIV_SUP     = 2'b01,
        PRIV_USR     = 2'b10,
        PRIV_USR_ALT = 2'b11
    } priv_e;

    // Address regions, decided by the three top address bits.
    typedef enum logic [2:0] {
        SEG_USER   = 3'd0,   // low half, all levels
        SEG_KDIRC  = 3'd1,   // kernel direct window, cached
        SEG_KDIRU  = 3'd2,   // kernel direct window, uncached
        SEG_SMAP   = 3'd3,   // page mapped, supervisor or kernel
        SEG_KMAP   = 3'd4    // page mapped, kernel only
    } seg_e;

    // How an allowed access is resolved.
    typedef enum logic {
        ROUTE_DIRECT = 1'b0,
        ROUTE_TLB    = 1'b1
    } route_e;

    // Final outcome of one access.
    typedef enum logic [1:0] {
        OUT_DIRECT = 2'd0,
        OUT_TLB    = 2'd1,
        OUT_BAD    = 2'd2
    } outcome_e;

endpackage

// File: rtl/vseg_region_decode.sv
module vseg_region_decode
    import vseg_pkg::*;
(
    input  logic [2:0] top_bits,
    output seg_e       seg
);

    always_comb begin
        seg = SEG_USER;
        unique casez (top_bits)
            3'b0??:  seg = SEG_USER;
            3'b100:  seg = SEG_KDIRC;
            3'b101:  seg = SEG_KDIRU;
            3'b110:  seg = SEG_SMAP;
            3'b111:  seg = SEG_KMAP;
            default: seg = SEG_USER;
        endcase
    end

endmodule

// File: rtl/vseg_access_gate.sv
module vseg_access_gate
    import vseg_pkg::*;
(
    input  seg_e       seg,
    input  logic [1:0] priv_mode,
    output logic       allowed
);

    logic is_kern;
    logic is_sup;

    always_comb begin
        is_kern = 1'b0;
        is_sup  = 1'b0;
        unique case (priv_e'(priv_mode))
            PRIV_KERN:    is_kern = 1'b1;
            PRIV_SUP:     is_sup  = 1'b1;
            PRIV_USR,
            PRIV_USR_ALT: ;
            default:      ;
        endcase
    end

    always_comb begin
        allowed = 1'b0;
        unique case (seg)
            SEG_USER:  allowed = 1'b1;
            SEG_KDIRC: allowed = is_kern;
            SEG_KDIRU: allowed = is_kern;
            SEG_SMAP:  allowed = is_kern | is_sup;
            SEG_KMAP:  allowed = is_kern;
            default:   allowed = 1'b0;
        endcase
    end

endmodule

// File: rtl/vseg_phys_map.sv
module vseg_phys_map
    import vseg_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  seg_e              seg,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic              err_lvl,
    input  logic              fixed_map,
    output logic [ADDR_W-1:0] paddr,
    output route_e            route
);

    localparam logic [ADDR_W-1:0] KDIRC_BASE = {3'b100, {(ADDR_W-3){1'b0}}};
    localparam logic [ADDR_W-1:0] KDIRU_BASE = {3'b101, {(ADDR_W-3){1'b0}}};
    localparam logic [ADDR_W-1:0] FIX_OFS    = {2'b01,  {(ADDR_W-2){1'b0}}};
    localparam logic [ADDR_W-1:0] WIN_MASK   = {3'b000, {(ADDR_W-3){1'b1}}};

    always_comb begin
        paddr = '0;
        route = ROUTE_DIRECT;
        unique case (seg)
            SEG_USER: begin
                if (err_lvl) begin
                    paddr = vaddr;
                end else if (fixed_map) begin
                    paddr = vaddr + FIX_OFS;
                end else begin
                    route = ROUTE_TLB;
                end
            end
            SEG_KDIRC: paddr = fixed_map ? (vaddr & WIN_MASK) : (vaddr - KDIRC_BASE);
            SEG_KDIRU: paddr = fixed_map ? (vaddr & WIN_MASK) : (vaddr - KDIRU_BASE);
            SEG_SMAP,
            SEG_KMAP: begin
                if (fixed_map) begin
                    paddr = vaddr;
                end else begin
                    route = ROUTE_TLB;
                end
            end
            default: route = ROUTE_TLB;
        endcase
    end

endmodule

// File: rtl/vseg_out_stage.sv
module vseg_out_stage #(
    parameter int ADDR_W  = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] d_paddr,
    input  logic              d_tlb,
    input  logic              d_bad,
    input  logic              d_rd,
    input  logic              d_wr,
    output logic [ADDR_W-1:0] q_paddr,
    output logic              q_tlb,
    output logic              q_bad,
    output logic              q_rd,
    output logic              q_wr
);

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q_paddr <= '0;
                    q_tlb   <= 1'b0;
                    q_bad   <= 1'b0;
                    q_rd    <= 1'b0;
                    q_wr    <= 1'b0;
                end else begin
                    q_paddr <= d_paddr;
                    q_tlb   <= d_tlb;
                    q_bad   <= d_bad;
                    q_rd    <= d_rd;
                    q_wr    <= d_wr;
                end
            end
        end else begin : g_comb
            assign q_paddr = d_paddr;
            assign q_tlb   = d_tlb;
            assign q_bad   = d_bad;
            assign q_rd    = d_rd;
            assign q_wr    = d_wr;
        end
    endgenerate

endmodule

// File: rtl/vseg_xlate.sv
module vseg_xlate
    import vseg_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [1:0]        priv_mode,
    input  logic              err_lvl,
    input  logic              fixed_map,
    output logic [ADDR_W-1:0] paddr,
    output logic              need_tlb,
    output logic              bad_addr,
    output logic              rd_ok,
    output logic              wr_ok
);

    localparam logic [ADDR_W-1:0] FIX_OFS = {2'b01, {(ADDR_W-2){1'b0}}};

    seg_e              seg;
    logic              allowed;
    route_e            route;
    logic [ADDR_W-1:0] map_paddr;
    outcome_e          outcome;

    logic [ADDR_W-1:0] c_paddr;
    logic              c_tlb;
    logic              c_bad;
    logic              c_direct;

    vseg_region_decode u_region (
        .top_bits (vaddr[ADDR_W-1 -: 3]),
        .seg      (seg)
    );

    vseg_access_gate u_gate (
        .seg       (seg),
        .priv_mode (priv_mode),
        .allowed   (allowed)
    );

    vseg_phys_map #(.ADDR_W(ADDR_W)) u_map (
        .seg       (seg),
        .vaddr     (vaddr),
        .err_lvl   (err_lvl),
        .fixed_map (fixed_map),
        .paddr     (map_paddr),
        .route     (route)
    );

    // Outcome selection: privilege error wins over any mapping decision.
    always_comb begin
        if (!allowed) begin
            outcome = OUT_BAD;
        end else if (route == ROUTE_TLB) begin
            outcome = OUT_TLB;
        end else begin
            outcome = OUT_DIRECT;
        end
    end

    always_comb begin
        c_paddr  = '0;
        c_tlb    = 1'b0;
        c_bad    = 1'b0;
        c_direct = 1'b0;
        unique case (outcome)
            OUT_DIRECT: begin
                c_direct = 1'b1;
                c_paddr  = map_paddr;
            end
            OUT_TLB:    c_tlb = 1'b1;
            OUT_BAD:    c_bad = 1'b1;
            default:    c_bad = 1'b1;
        endcase
    end

    vseg_out_stage #(.ADDR_W(ADDR_W), .REG_OUT(REG_OUT)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_paddr (c_paddr),
        .d_tlb   (c_tlb),
        .d_bad   (c_bad),
        .d_rd    (c_direct),
        .d_wr    (c_direct),
        .q_paddr (paddr),
        .q_tlb   (need_tlb),
        .q_bad   (bad_addr),
        .q_rd    (rd_ok),
        .q_wr    (wr_ok)
    );

    // ---------------- assertions ----------------
    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bad_addr && need_tlb))
        else $error("bad_addr and need_tlb together");

    p_perm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok || wr_ok) |-> (rd_ok && wr_ok && !bad_addr && !need_tlb))
        else $error("permission flags inconsistent with outcome");

    generate
        if (REG_OUT) begin : g_chk
            logic primed;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) primed <= 1'b0;
                else        primed <= 1'b1;
            end

            p_user_high_bad_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (primed && $past(priv_mode[1] && vaddr[ADDR_W-1])) |-> bad_addr)
                else $error("user access to high half not rejected");

            p_erl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
                (primed && $past(!vaddr[ADDR_W-1] && err_lvl))
                |-> (!need_tlb && !bad_addr && paddr == $past(vaddr)))
                else $error("error-level identity map broken");

            p_kmap_tlb_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (primed && $past(priv_mode == 2'b00 && vaddr[ADDR_W-1 -: 3] == 3'b111 && !fixed_map))
                |-> need_tlb)
                else $error("kernel mapped top window not sent to lookup");

            p_fixed_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (primed && $past(fixed_map && !err_lvl && !vaddr[ADDR_W-1]))
                |-> (!need_tlb && paddr == ($past(vaddr) + FIX_OFS)))
                else $error("fixed-map low relocation wrong");
        end
    endgenerate

endmodule

// File: tb/vseg_xlate_tb.sv
module vseg_xlate_tb;

    typedef struct {
        string       tag;
        logic [31:0] va;
        logic        bad;
        logic        tlb;
        logic        direct;
        logic [31:0] pa;
    } item_t;

    logic        clk;
    logic        rst_n;
    logic [31:0] vaddr;
    logic [1:0]  priv_mode;
    logic        err_lvl;
    logic        fixed_map;
    logic [31:0] paddr;
    logic        need_tlb;
    logic        bad_addr;
    logic        rd_ok;
    logic        wr_ok;

    int    n_checks = 0;
    int    n_fails  = 0;
    item_t sb_q[$];

    vseg_xlate u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .vaddr     (vaddr),
        .priv_mode (priv_mode),
        .err_lvl   (err_lvl),
        .fixed_map (fixed_map),
        .paddr     (paddr),
        .need_tlb  (need_tlb),
        .bad_addr  (bad_addr),
        .rd_ok     (rd_ok),
        .wr_ok     (wr_ok)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    // Reference model built from the requirements.
    function automatic item_t model(string tag, logic [31:0] va, logic [1:0] md,
                                    logic el, logic fx);
        item_t it;
        logic kern;
        logic usr;
        kern = (md == 2'b00);
        usr  = md[1];
        it.tag = tag; it.va = va;
        it.bad = 1'b0; it.tlb = 1'b0; it.direct = 1'b0; it.pa = 32'h0;
        if (!va[31]) begin
            if (el)      begin it.direct = 1'b1; it.pa = va; end
            else if (fx) begin it.direct = 1'b1; it.pa = va + 32'h4000_0000; end
            else         it.tlb = 1'b1;
        end else if (va < 32'hC000_0000) begin
            if (!kern) it.bad = 1'b1;
            else begin
                it.direct = 1'b1;
                if (fx)                     it.pa = va & 32'h1FFF_FFFF;
                else if (va < 32'hA000_0000) it.pa = va - 32'h8000_0000;
                else                        it.pa = va - 32'hA000_0000;
            end
        end else if (va < 32'hE000_0000) begin
            if (usr)     it.bad = 1'b1;
            else if (fx) begin it.direct = 1'b1; it.pa = va; end
            else         it.tlb = 1'b1;
        end else begin
            if (!kern)   it.bad = 1'b1;
            else if (fx) begin it.direct = 1'b1; it.pa = va; end
            else         it.tlb = 1'b1;
        end
        return it;
    endfunction

    task automatic drive(string tag, logic [31:0] va, logic [1:0] md, logic el, logic fx);
        @(negedge clk);
        vaddr     = va;
        priv_mode = md;
        err_lvl   = el;
        fixed_map = fx;
        sb_q.push_back(model(tag, va, md, el, fx));
    endtask

    // Monitor: one clock after each drive, compare against the scoreboard head.
    always @(posedge clk) begin
        #1;
        if (rst_n && sb_q.size() > 0) begin
            item_t e;
            logic  ok;
            e  = sb_q.pop_front();
            ok = (bad_addr === e.bad) && (need_tlb === e.tlb) &&
                 (rd_ok === e.direct) && (wr_ok === e.direct) &&
                 (!e.direct || paddr === e.pa);
            n_checks++;
            if (!ok) begin
                n_fails++;
                $display("FAIL %s va=%h got bad=%b tlb=%b rw=%b%b pa=%h exp bad=%b tlb=%b rw=%b%b pa=%h",
                         e.tag, e.va, bad_addr, need_tlb, rd_ok, wr_ok, paddr,
                         e.bad, e.tlb, e.direct, e.direct, e.pa);
            end
        end
    end

    initial begin
        #(8 * 150000);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; vaddr = 32'hFFFF_FFFF; priv_mode = 2'b00; err_lvl = 1'b1; fixed_map = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset values
        n_checks++;
        if (paddr !== 32'h0 || need_tlb !== 1'b0 || bad_addr !== 1'b0 ||
            rd_ok !== 1'b0 || wr_ok !== 1'b0) begin
            n_fails++;
            $display("FAIL R10 reset got pa=%h tlb=%b bad=%b rw=%b%b exp all zero",
                     paddr, need_tlb, bad_addr, rd_ok, wr_ok);
        end
        rst_n = 1'b1;

        // R1: error-level identity map on the low half
        drive("R1", 32'h1234_5678, 2'b00, 1'b1, 1'b0);
        drive("R1", 32'h7FFF_FFFF, 2'b10, 1'b1, 1'b0);
        drive("R1", 32'h0000_0000, 2'b01, 1'b1, 1'b1);
        // R2: low half goes to lookup
        drive("R2", 32'h0000_1000, 2'b10, 1'b0, 1'b0);
        drive("R2", 32'h7FFF_FFFF, 2'b01, 1'b0, 1'b0);
        drive("R2", 32'h4000_0000, 2'b00, 1'b0, 1'b0);
        // R3: user (including code 11) on high half
        drive("R3", 32'h8000_0000, 2'b10, 1'b0, 1'b0);
        drive("R3", 32'hC000_0000, 2'b11, 1'b0, 1'b0);
        drive("R3", 32'hFFFF_FFFF, 2'b10, 1'b1, 1'b1);
        drive("R3", 32'hA000_0000, 2'b11, 1'b0, 1'b0);
        // R4: kernel direct windows
        drive("R4", 32'h8000_0000, 2'b00, 1'b0, 1'b0);
        drive("R4", 32'h9FFF_FFFF, 2'b00, 1'b0, 1'b0);
        drive("R4", 32'hA000_0000, 2'b00, 1'b0, 1'b0);
        drive("R4", 32'hBFFF_FFFC, 2'b00, 1'b0, 1'b0);
        drive("R4", 32'h8000_1234, 2'b00, 1'b1, 1'b0);
        // R5: supervisor rejected from kernel windows
        drive("R5", 32'h8000_0000, 2'b01, 1'b0, 1'b0);
        drive("R5", 32'hA000_0010, 2'b01, 1'b0, 1'b0);
        drive("R5", 32'hE000_0000, 2'b01, 1'b0, 1'b0);
        drive("R5", 32'hFFFF_FFFF, 2'b01, 1'b0, 1'b1);
        // R6: mapped windows
        drive("R6", 32'hC000_0000, 2'b01, 1'b0, 1'b0);
        drive("R6", 32'hDFFF_FFFF, 2'b00, 1'b0, 1'b0);
        drive("R6", 32'hE000_0000, 2'b00, 1'b0, 1'b0);
        drive("R6", 32'hFFFF_FFFF, 2'b00, 1'b1, 1'b0);
        // R7: fixed-map relocation
        drive("R7", 32'h0000_0000, 2'b00, 1'b0, 1'b1);
        drive("R7", 32'h7FFF_FFFF, 2'b10, 1'b0, 1'b1);
        drive("R7", 32'h8000_0010, 2'b00, 1'b0, 1'b1);
        drive("R7", 32'hBFFF_FFFF, 2'b00, 1'b0, 1'b1);
        drive("R7", 32'hE000_0004, 2'b00, 1'b0, 1'b1);
        drive("R7", 32'hC000_0008, 2'b01, 1'b0, 1'b1);
        drive("R7", 32'hC000_0000, 2'b10, 1'b0, 1'b1);
        // R8: permission flags on direct versus other outcomes
        drive("R8", 32'h9000_0000, 2'b00, 1'b0, 1'b0);
        drive("R8", 32'h9000_0000, 2'b01, 1'b0, 1'b0);
        // R9/R10: full sweep, back-to-back every clock
        for (int r = 0; r < 8; r++) begin
            for (int m = 0; m < 4; m++) begin
                for (int k = 0; k < 4; k++) begin
                    drive("R9", {r[2:0], 29'h0ABC_DE4} | (k[0] ? 32'h1FFF_FFFF : 32'h0),
                          m[1:0], k[1], k[0]);
                end
            end
        end

        repeat (3) @(negedge clk);
        n_checks++;
        if (sb_q.size() != 0) begin
            n_fails++;
            $display("FAIL R10 pending results got %0d exp 0", sb_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule